// File: doc/BRIEF.md
# Variable Node Update Unit with Embedded Hard Decision

This block is the variable-side processor of a partially parallel quasi-cyclic LDPC decoder that runs the normalized min-sum schedule. For one code bit it takes the channel (intrinsic) value and the `GAMMA` check-to-variable messages that arrive from the block rows of its block column. It returns the saturated posterior value and `GAMMA` new variable-to-check messages. The posterior is the intrinsic value plus every incoming message. Each outgoing message is that posterior minus the message that came in on the same edge.

Each outgoing lane is one bit wider than a message. Its top bit carries the tentative hard decision, which is the sign of the posterior. The check side can therefore run its parity test straight from the message word, and the decoder needs no separate hard-decision store per block column. The lanes come out in the same order as the incoming messages, so the surrounding memory logic writes each result back to the slot it read from. An init mode sends the intrinsic value out on every lane. This is used to load the message stores before the first iteration.

The unit is a single register stage. A word presented with `in_valid_i` high appears on the outputs one clock later. The outputs keep their value until the next valid word arrives.

Top module: `vnu_top`

## Requirements
- R1: In update mode (`init_i` = 0), `post_o` equals the two's-complement sum of `intr_i` and all `GAMMA` message fields of `c2v_i`, saturated as in R4. Field k of `c2v_i` occupies bits [k*MSG_W +: MSG_W].
- R2: In update mode, bits [MSG_W-1:0] of output lane k (`v2c_o` bits [k*(MSG_W+1) +: MSG_W+1]) equal the unsaturated posterior minus c2v field k, saturated as in R4. Lane k always belongs to input field k.
- R3: Bit MSG_W of every lane (the lane head) is the hard decision. It is 1 exactly when the unsaturated posterior is negative and 0 when it is zero or positive. In init mode it is the sign bit of `intr_i`. It always equals bit MSG_W-1 of `post_o`.
- R4: Update-mode results saturate to the symmetric range [-(2^(MSG_W-1)-1), 2^(MSG_W-1)-1], which is [-31, 31] for 6-bit messages. Internal sums are wide enough that they never wrap.
- R5: In init mode (`init_i` = 1), every lane message and `post_o` equal `intr_i` unchanged, including the value -2^(MSG_W-1). The `c2v_i` inputs have no effect.
- R6: `out_valid_o` is high in exactly the cycle that follows a cycle with `in_valid_i` high, and the results of that input are on the outputs in that same cycle.
- R7: While `in_valid_i` is low, `post_o` and `v2c_o` hold their last values, whatever the data inputs do.
- R8: While `rst_n` is low (asynchronous, active low), `out_valid_o`, `post_o` and `v2c_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input word is valid this cycle |
| init_i | input | 1 | 1 = intrinsic pass-through, 0 = node update |
| intr_i | input | MSG_W | Intrinsic channel value, two's complement |
| c2v_i | input | GAMMA*MSG_W | Check-to-variable messages, field k per block row k |
| out_valid_o | output | 1 | Result valid |
| post_o | output | MSG_W | Saturated posterior value |
| v2c_o | output | GAMMA*(MSG_W+1) | Outgoing lanes, each {hard bit, message} |

## Verification
A wrong internal sum appears at the next valid output as a posterior or lane value that differs from the clamped integer arithmetic. A wrong sign decision appears there as a lane head that disagrees with the sign of `post_o`. A mistake in lane routing or in the edge subtraction appears on the first vector whose incoming messages differ from each other. A saturation or wrap error appears on the first vector whose sum lies outside the message range. Each of these faults is visible one clock after the offending input and never later. A stale-hold fault appears in the first idle cycle that follows.

// File: rtl/vnu_pkg.sv
`timescale 1ns/1ps
package vnu_pkg;

  typedef enum logic {
    MODE_UPDATE = 1'b0,
    MODE_INIT   = 1'b1
  } vnu_mode_e;

  // Largest magnitude of a message (symmetric range).
  function automatic int msg_limit(input int mw);
    return (1 << (mw - 1)) - 1;
  endfunction

  // Clamp a wide value into the symmetric message range.
  function automatic int sat_msg(input int v, input int mw);
    int lim;
    lim = msg_limit(mw);
    if (v > lim)       return lim;
    else if (v < -lim) return -lim;
    else               return v;
  endfunction

endpackage

// File: rtl/vnu_sum_tree.sv
`timescale 1ns/1ps
module vnu_sum_tree #(
  parameter int GAMMA = 3,
  parameter int MSG_W = 6,
  parameter int SUM_W = 10
) (
  input  logic [MSG_W-1:0]       intr_i,
  input  logic [GAMMA*MSG_W-1:0] c2v_i,
  output logic [SUM_W-1:0]       z_o
);
  logic signed [SUM_W-1:0] acc [GAMMA+1];

  assign acc[0] = SUM_W'($signed(intr_i));

  for (genvar g = 0; g < GAMMA; g++) begin : g_acc
    assign acc[g+1] = acc[g] + SUM_W'($signed(c2v_i[g*MSG_W +: MSG_W]));
  end

  assign z_o = acc[GAMMA];
endmodule

// File: rtl/vnu_edge.sv
`timescale 1ns/1ps
module vnu_edge
  import vnu_pkg::*;
#(
  parameter int MSG_W = 6,
  parameter int SUM_W = 10
) (
  input  logic [SUM_W-1:0] z_i,
  input  logic [MSG_W-1:0] c2v_i,
  input  logic [MSG_W-1:0] intr_i,
  input  vnu_mode_e        mode_i,
  input  logic             hard_i,
  output logic [MSG_W:0]   lane_o
);
  logic signed [SUM_W-1:0] extr;
  logic [MSG_W-1:0]        extr_sat;

  assign extr     = $signed(z_i) - SUM_W'($signed(c2v_i));
  assign extr_sat = MSG_W'(sat_msg(int'(extr), MSG_W));

  always_comb begin
    if (mode_i == MODE_INIT) lane_o = {hard_i, intr_i};
    else                     lane_o = {hard_i, extr_sat};
  end
endmodule

// File: rtl/vnu_top.sv
`timescale 1ns/1ps
module vnu_top
  import vnu_pkg::*;
#(
  parameter int GAMMA = 3,
  parameter int MSG_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid_i,
  input  logic                       init_i,
  input  logic [MSG_W-1:0]           intr_i,
  input  logic [GAMMA*MSG_W-1:0]     c2v_i,
  output logic                       out_valid_o,
  output logic [MSG_W-1:0]           post_o,
  output logic [GAMMA*(MSG_W+1)-1:0] v2c_o
);
  localparam int SUM_W  = MSG_W + $clog2(GAMMA + 2) + 1;
  localparam int LANE_W = MSG_W + 1;

  vnu_mode_e                   mode;
  logic [SUM_W-1:0]            z_full;
  logic                        z_neg;
  logic                        hard_bit;
  logic [MSG_W-1:0]            post_d;
  logic [GAMMA*LANE_W-1:0]     lanes_d;

  assign mode = init_i ? MODE_INIT : MODE_UPDATE;

  vnu_sum_tree #(.GAMMA(GAMMA), .MSG_W(MSG_W), .SUM_W(SUM_W)) sum_i (
    .intr_i (intr_i),
    .c2v_i  (c2v_i),
    .z_o    (z_full)
  );

  // Named event: the unsaturated posterior is negative.
  assign z_neg    = z_full[SUM_W-1];
  assign hard_bit = (mode == MODE_INIT) ? intr_i[MSG_W-1] : z_neg;
  assign post_d   = (mode == MODE_INIT) ? intr_i
                  : MSG_W'(sat_msg(int'($signed(z_full)), MSG_W));

  for (genvar k = 0; k < GAMMA; k++) begin : g_edge
    vnu_edge #(.MSG_W(MSG_W), .SUM_W(SUM_W)) edge_i (
      .z_i    (z_full),
      .c2v_i  (c2v_i[k*MSG_W +: MSG_W]),
      .intr_i (intr_i),
      .mode_i (mode),
      .hard_i (hard_bit),
      .lane_o (lanes_d[k*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      post_o      <= '0;
      v2c_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        post_o <= post_d;
        v2c_o  <= lanes_d;
      end
    end
  end
endmodule

// File: rtl/vnu_top_chk.sv
`timescale 1ns/1ps
module vnu_top_chk #(
  parameter int GAMMA = 3,
  parameter int MSG_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid_i,
  input logic                       init_i,
  input logic [MSG_W-1:0]           intr_i,
  input logic [GAMMA*(MSG_W+1)-1:0] v2c_o,
  input logic                       out_valid_o,
  input logic [MSG_W-1:0]           post_o
);
  localparam int LANE_W = MSG_W + 1;
  localparam int LIM    = (1 << (MSG_W - 1)) - 1;

  logic             last_init;
  logic [MSG_W-1:0] last_intr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_init <= 1'b0;
      last_intr <= '0;
    end else if (in_valid_i) begin
      last_init <= init_i;
      last_intr <= intr_i;
    end
  end

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(post_o) && $stable(v2c_o)));

  for (genvar k = 0; k < GAMMA; k++) begin : g_lane
    p_head_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (v2c_o[k*LANE_W + MSG_W] == post_o[MSG_W-1]));
    p_sat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !last_init) |->
        ($signed(v2c_o[k*LANE_W +: MSG_W]) >= -LIM));
    p_init_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && last_init) |->
        (v2c_o[k*LANE_W +: MSG_W] == last_intr));
  end
endmodule

bind vnu_top vnu_top_chk #(.GAMMA(GAMMA), .MSG_W(MSG_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid_i  (in_valid_i),
  .init_i      (init_i),
  .intr_i      (intr_i),
  .v2c_o       (v2c_o),
  .out_valid_o (out_valid_o),
  .post_o      (post_o)
);

// File: tb/vnu_top_tb_top.sv
`timescale 1ns/1ps
module vnu_top_tb_top;
  localparam int GAMMA = 3;
  localparam int MSG_W = 6;
  localparam int LANE_W = MSG_W + 1;
  localparam int NVEC = 9;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       in_valid_i = 1'b0;
  logic                       init_i = 1'b0;
  logic [MSG_W-1:0]           intr_i = '0;
  logic [GAMMA*MSG_W-1:0]     c2v_i = '0;
  logic                       out_valid_o;
  logic [MSG_W-1:0]           post_o;
  logic [GAMMA*LANE_W-1:0]    v2c_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vnu_top #(.GAMMA(GAMMA), .MSG_W(MSG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .init_i(init_i),
    .intr_i(intr_i), .c2v_i(c2v_i), .out_valid_o(out_valid_o),
    .post_o(post_o), .v2c_o(v2c_o)
  );

  // Vector: {init, intr, c0, c1, c2}; hex is 6-bit two's complement.
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 6'h05, 6'h03, 6'h3E, 6'h04},  // 5; 3,-2,4 -> z=10
    {1'b0, 6'h39, 6'h3C, 6'h3B, 6'h02},  // -7; -4,-5,2 -> z=-14
    {1'b0, 6'h03, 6'h3F, 6'h3E, 6'h00},  // z=0 exactly
    {1'b0, 6'h1F, 6'h1F, 6'h1F, 6'h1F},  // z=124, positive clamp
    {1'b0, 6'h20, 6'h20, 6'h20, 6'h20},  // z=-128, negative clamp
    {1'b1, 6'h37, 6'h0A, 6'h0A, 6'h0A},  // init, -9
    {1'b1, 6'h20, 6'h05, 6'h05, 6'h05},  // init, -32 passes
    {1'b0, 6'h14, 6'h0A, 6'h27, 6'h00},  // 20; 10,-25,0 -> z=5
    {1'b0, 6'h00, 6'h14, 6'h14, 6'h38}   // 0; 20,20,-8 -> z=32
  };

  function automatic int clamp(input int v);
    if (v > 31) return 31;
    if (v < -31) return -31;
    return v;
  endfunction

  function automatic int s6(input logic [5:0] x);
    return (x >= 6'd32) ? int'(x) - 64 : int'(x);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [24:0] v);
    int intr, z, c [GAMMA], exp_msg, exp_post, exp_hard;
    bit ini;
    ini  = v[24];
    intr = s6(v[23:18]);
    z    = intr;
    for (int k = 0; k < GAMMA; k++) begin
      c[k] = s6(v[17 - 6*k -: 6]);
      z += c[k];
    end
    @(negedge clk);
    in_valid_i = 1'b1;
    init_i     = ini;
    intr_i     = v[23:18];
    for (int k = 0; k < GAMMA; k++) c2v_i[k*MSG_W +: MSG_W] = v[17 - 6*k -: 6];
    @(negedge clk);
    in_valid_i = 1'b0;
    chk("R6 out_valid", int'(out_valid_o), 1);
    exp_post = ini ? intr : clamp(z);
    exp_hard = ini ? int'(intr < 0) : int'(z < 0);
    chk(ini ? "R5 post" : "R1 post", s6(post_o), exp_post);
    for (int k = 0; k < GAMMA; k++) begin
      exp_msg = ini ? intr : clamp(z - c[k]);
      chk(ini ? "R5 lane msg" : "R2/R4 lane msg",
          s6(v2c_o[k*LANE_W +: MSG_W]), exp_msg);
      chk("R3 lane head", int'(v2c_o[k*LANE_W + MSG_W]), exp_hard);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [MSG_W-1:0]        held_post;
    logic [GAMMA*LANE_W-1:0] held_v2c;
    #20;
    // R8: reset state
    chk("R8 out_valid", int'(out_valid_o), 0);
    chk("R8 post", int'(post_o), 0);
    chk("R8 v2c", int'(v2c_o != '0), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R7 + R6: idle cycles with changing data must not move outputs
    held_post = post_o;
    held_v2c  = v2c_o;
    init_i = 1'b0;
    intr_i = 6'h11;
    c2v_i  = 18'h2A5C3;
    @(negedge clk);
    chk("R6 out_valid low", int'(out_valid_o), 0);
    c2v_i  = 18'h01234;
    intr_i = 6'h2E;
    @(negedge clk);
    chk("R7 post held", int'(post_o), int'(held_post));
    chk("R7 v2c held", int'(v2c_o == held_v2c), 1);

    // R5: init ignores c2v (same intrinsic, different c2v)
    run_vec({1'b1, 6'h0C, 6'h1F, 6'h20, 6'h01});

    // R8: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R8 async out_valid", int'(out_valid_o), 0);
    chk("R8 async v2c", int'(v2c_o != '0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(VEC[0]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule